// File: doc/BRIEF.md
# Narrow-Access Register Adaptation Bridge

This bridge connects a host that issues 8-, 16- and 32-bit register reads and writes, laid out the way a standard SD host controller register block is laid out, to a backing register file that only accepts whole, word-aligned 32-bit accesses. Each host request is turned into at most one backing read and one backing write on the aligned word. Narrow writes are carried out as read-modify-write, and the byte or halfword is moved into its lane.

On the way through, a few registers get special treatment. Some fields sit at non-standard positions in the backing word, so they are moved. Some writes are dropped, or held back and merged with a later write. Certain bits are forced to 1 or cleared. Two configuration inputs, a byte-order select and a vendor revision code, adjust this behaviour. The host sees a one-request-at-a-time interface: a ready signal while idle, and a single-cycle response pulse when the request completes.

Top module: `sdb_bridge`

## Requirements
- R1: Every backing access uses the host address with bits 1:0 cleared. A read returns, zero-extended, the byte at lane (addr[1:0]×8), the halfword at lane (addr[1]×16), or the whole word, for size codes 0 (byte), 1 (halfword) and 2 (word).
- R2: A narrow write to an ordinary address reads the backing word, replaces only the addressed byte or halfword lane, and writes the whole word back.
- R3: A halfword write to address 0x0C (transfer mode) makes no backing access and completes in the cycle after acceptance; its value is kept in an internal shadow register.
- R4: A halfword write to address 0x0E (command) makes no backing read and writes one word whose upper 16 bits are the command value and whose lower 16 bits are the shadow value.
- R5: A word read of address 0x24 (present state) returns bits 19:0 unchanged, backing bits 27:24 at bits 23:20, backing bit 23 at bit 24, and zeros elsewhere.
- R6: A byte read of address 0x28 (host control) returns backing bits 9:8 at result bits 4:3; the other result bits come from backing bits 7:0.
- R7: A byte write to 0x28 stores value bits 4:3 at backing bits 9:8 and keeps the old backing bits 4:3. It writes the other value bits into bits 7:0 and then clears the reserved mask (default: bit 2, high-speed enable).
- R8: A byte write to address 0x29 (power control) is dropped: no backing access takes place and the word is left as it was.
- R9: Every word write to address 0x34 (interrupt enable) stores bit 2 (block-gap event enable) as 1.
- R10: A halfword write to address 0x04 (block size) stores bits 14:12 as 0.
- R11: A word read of address 0x40 (capabilities) with bit 20 set returns bit 19 also set when the vendor code is above 0x12, and returns bit 19 unchanged otherwise.
- R12: A halfword read of address 0xFE (host version) returns the low 16 bits of its word, whatever the lane.
- R13: With the byte-order input high, the backing word is byte-reversed on both read and write. After reset the shadow register is zero, so a command write with no prior transfer-mode write stores zeros in the low half.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_big_endian | input | 1 | 1: backing bus words are byte-reversed |
| cfg_vendor_ver | input | 8 | Vendor revision code of the register file |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Bridge idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word |
| req_addr | input | 8 | Host byte address |
| req_wdata | input | 32 | Write value, right-aligned |
| rsp_valid | output | 1 | Single-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, right-aligned (zero for writes) |
| bk_rd | output | 1 | Backing read strobe; data expected one cycle later |
| bk_wr | output | 1 | Backing write strobe |
| bk_addr | output | 8 | Word-aligned backing address |
| bk_wdata | output | 32 | Backing write word |
| bk_rdata | input | 32 | Backing read word |

## Verification
The byte-order stage and the per-register field remapping act on the same word in the same cycle. A host-control byte write in big-endian mode makes both happen at once: the read-back is reversed, the DMA-select field is moved up, the reserved bit is cleared, and the result is reversed again. The bench judges this by comparing the raw word left in its backing model against the byte-reversed expected word. The shadow capture and the command merge are split across requests. A transfer-mode write followed by a command write checks that the merged word holds both values and that no backing read was issued.

// File: rtl/sdb_pkg.sv
package sdb_pkg;
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;

  localparam logic [7:0] A_BLKSZ  = 8'h04;
  localparam logic [7:0] A_XFER   = 8'h0C;
  localparam logic [7:0] A_CMD    = 8'h0E;
  localparam logic [7:0] A_PSTATE = 8'h24;
  localparam logic [7:0] A_HCTL   = 8'h28;
  localparam logic [7:0] A_PWR    = 8'h29;
  localparam logic [7:0] A_INTEN  = 8'h34;
  localparam logic [7:0] A_CAPS   = 8'h40;
  localparam logic [7:0] A_HVER   = 8'hFE;

  localparam logic [7:0] VENDOR_ADMA2_MIN = 8'h12;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD, ST_MOD, ST_WR, ST_RSP
  } sdb_state_e;
endpackage

// File: rtl/sdb_bswap.sv
module sdb_bswap #(
  parameter int DATA_W = 32
) (
  input  logic              en,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);
  localparam int NB = DATA_W / 8;
  for (genvar i = 0; i < NB; i++) begin : g_lane
    assign dout[8*i +: 8] = en ? din[8*(NB-1-i) +: 8] : din[8*i +: 8];
  end
endmodule

// File: rtl/sdb_read_fix.sv
module sdb_read_fix
  import sdb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size,
  input  logic [7:0]        addr,
  input  logic [7:0]        vendor,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);
  logic [DATA_W-1:0] shifted_b, shifted_h;
  logic [7:0]        b;

  always_comb begin
    shifted_b = word >> {addr[1:0], 3'b000};
    shifted_h = word >> {addr[1], 4'b0000};
    b         = shifted_b[7:0];
    result    = '0;
    if (size == SZ_BYTE) begin
      if (addr == A_HCTL) b[4:3] = word[9:8];
      result[7:0] = b;
    end else if (size == SZ_HALF) begin
      result[15:0] = (addr == A_HVER) ? word[15:0] : shifted_h[15:0];
    end else if (addr == A_PSTATE) begin
      result[19:0]  = word[19:0];
      result[23:20] = word[27:24];
      result[24]    = word[23];
    end else begin
      result = word;
      if (addr == A_CAPS && word[20] && vendor > VENDOR_ADMA2_MIN)
        result[19] = 1'b1;
    end
  end
endmodule

// File: rtl/sdb_write_merge.sv
module sdb_write_merge
  import sdb_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] HCTL_RSVD = 32'h0000_0004
) (
  input  logic [1:0]        size,
  input  logic [7:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] old_word,
  input  logic [15:0]       shadow,
  output logic [DATA_W-1:0] result
);
  logic [4:0] lane_b, lane_h;

  always_comb begin
    lane_b = {addr[1:0], 3'b000};
    lane_h = {addr[1], 4'b0000};
    result = old_word;
    if (size == SZ_BYTE) begin
      if (addr == A_HCTL) begin
        result[9:8] = wdata[4:3];
        result[7:0] = {wdata[7:5], old_word[4:3], wdata[2:0]};
        result      = result & ~HCTL_RSVD;
      end else begin
        result[lane_b +: 8] = wdata[7:0];
      end
    end else if (size == SZ_HALF) begin
      if (addr == A_CMD) begin
        result = {wdata[15:0], shadow};
      end else begin
        result[lane_h +: 16] = wdata[15:0];
        if (addr == A_BLKSZ) result[14:12] = 3'b000;
      end
    end else begin
      result = wdata;
      if (addr == A_INTEN) result[2] = 1'b1;
    end
  end
endmodule

// File: rtl/sdb_bridge.sv
module sdb_bridge
  import sdb_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] HCTL_RSVD = 32'h0000_0004
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_big_endian,
  input  logic [7:0]        cfg_vendor_ver,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bk_rd,
  output logic              bk_wr,
  output logic [ADDR_W-1:0] bk_addr,
  output logic [DATA_W-1:0] bk_wdata,
  input  logic [DATA_W-1:0] bk_rdata
);
  localparam int HALF_W = DATA_W / 2;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_li;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_li = rst_sync_q[1];

  sdb_state_e        state_q, state_d;
  logic              op_we_q;
  logic [1:0]        op_sz_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wd_q;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic [HALF_W-1:0] shadow_q, shadow_d;
  logic              ld_op, ld_hold, ld_shadow;

  logic [DATA_W-1:0] bk_word_in, rd_fixed, wr_word;

  sdb_bswap #(.DATA_W(DATA_W)) u_swap_in (
    .en(cfg_big_endian), .din(bk_rdata), .dout(bk_word_in)
  );

  sdb_read_fix #(.DATA_W(DATA_W)) u_rfix (
    .size(op_sz_q), .addr(op_addr_q), .vendor(cfg_vendor_ver),
    .word(bk_word_in), .result(rd_fixed)
  );

  sdb_write_merge #(.DATA_W(DATA_W), .HCTL_RSVD(HCTL_RSVD)) u_wmerge (
    .size(op_sz_q), .addr(op_addr_q), .wdata(op_wd_q),
    .old_word(hold_q), .shadow(shadow_q), .result(wr_word)
  );

  sdb_bswap #(.DATA_W(DATA_W)) u_swap_out (
    .en(cfg_big_endian), .din(wr_word), .dout(bk_wdata)
  );

  // next-state logic
  always_comb begin
    state_d   = state_q;
    hold_d    = hold_q;
    shadow_d  = shadow_q;
    ld_op     = 1'b0;
    ld_hold   = 1'b0;
    ld_shadow = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_op = 1'b1;
          if (req_write && req_size == SZ_HALF && req_addr == A_XFER) begin
            ld_shadow = 1'b1;
            shadow_d  = req_wdata[HALF_W-1:0];
            state_d   = ST_RSP;
          end else if (req_write && req_size == SZ_BYTE && req_addr == A_PWR) begin
            state_d = ST_RSP;
          end else if (req_write && (req_size[1] ||
                       (req_size == SZ_HALF && req_addr == A_CMD))) begin
            state_d = ST_WR;
          end else begin
            state_d = ST_RD;
          end
        end
      end
      ST_RD:  state_d = ST_MOD;
      ST_MOD: begin
        ld_hold = 1'b1;
        hold_d  = op_we_q ? bk_word_in : rd_fixed;
        state_d = op_we_q ? ST_WR : ST_RSP;
      end
      ST_WR:  state_d = ST_RSP;
      ST_RSP: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_li) begin
    if (!rst_li) begin
      state_q   <= ST_IDLE;
      op_we_q   <= 1'b0;
      op_sz_q   <= 2'd0;
      op_addr_q <= '0;
      op_wd_q   <= '0;
      hold_q    <= '0;
      shadow_q  <= '0;
    end else begin
      state_q <= state_d;
      if (ld_op) begin
        op_we_q   <= req_write;
        op_sz_q   <= req_size;
        op_addr_q <= req_addr;
        op_wd_q   <= req_wdata;
      end
      if (ld_hold)   hold_q   <= hold_d;
      if (ld_shadow) shadow_q <= shadow_d;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign bk_rd     = (state_q == ST_RD);
  assign bk_wr     = (state_q == ST_WR);
  assign bk_addr   = {op_addr_q[ADDR_W-1:2], 2'b00};
  assign rsp_valid = (state_q == ST_RSP);
  assign rsp_rdata = op_we_q ? '0 : hold_q;
endmodule

// File: rtl/sdb_checker.sv
module sdb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_big_endian,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [1:0]  req_size,
  input logic [7:0]  req_addr,
  input logic        rsp_valid,
  input logic        bk_rd,
  input logic        bk_wr,
  input logic [7:0]  bk_addr,
  input logic [31:0] bk_wdata
);
  logic acc;
  assign acc = req_valid && req_ready;

  p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bk_rd || bk_wr) |-> (bk_addr[1:0] == 2'b00));

  p_xfer_noaccess_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_size == 2'd1 && req_addr == 8'h0C)
    |=> (rsp_valid && !bk_rd && !bk_wr));

  p_cmd_direct_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_size == 2'd1 && req_addr == 8'h0E)
    |=> (bk_wr && !bk_rd));

  p_pwr_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_size == 2'd0 && req_addr == 8'h29)
    |=> (rsp_valid && !bk_rd && !bk_wr));

  p_inten_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_write && req_size == 2'd2 && req_addr == 8'h34)
    |=> (bk_wr && (cfg_big_endian ? bk_wdata[26] : bk_wdata[2])));

  p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bk_rd && bk_wr));
endmodule

bind sdb_bridge sdb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_size(req_size), .req_addr(req_addr), .rsp_valid(rsp_valid),
  .bk_rd(bk_rd), .bk_wr(bk_wr), .bk_addr(bk_addr), .bk_wdata(bk_wdata)
);

// File: tb/tb_sdb_bridge.sv
module tb_sdb_bridge;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, cfg_big_endian;
  logic [7:0]  cfg_vendor_ver;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_size;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        bk_rd, bk_wr;
  logic [7:0]  bk_addr;
  logic [31:0] bk_wdata, bk_rdata;

  sdb_bridge dut (
    .clk(clk), .rst_n(rst_n), .cfg_big_endian(cfg_big_endian),
    .cfg_vendor_ver(cfg_vendor_ver), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .bk_rd(bk_rd), .bk_wr(bk_wr), .bk_addr(bk_addr),
    .bk_wdata(bk_wdata), .bk_rdata(bk_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // backing register file model: read data one cycle after the strobe
  logic [31:0] mem [0:63];
  logic        ld_en;
  logic [5:0]  ld_idx;
  logic [31:0] ld_val;
  int          rd_cnt, wr_cnt;
  always @(posedge clk) begin
    if (ld_en) mem[ld_idx] <= ld_val;
    if (bk_wr) begin mem[bk_addr[7:2]] <= bk_wdata; wr_cnt <= wr_cnt + 1; end
    if (bk_rd) begin bk_rdata <= mem[bk_addr[7:2]]; rd_cnt <= rd_cnt + 1; end
  end

  int checks, errors;
  bit done;

  function automatic logic [31:0] rev(input logic [31:0] x);
    return {x[7:0], x[15:8], x[23:16], x[31:24]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic preload(input logic [7:0] addr, input logic [31:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = addr[7:2]; ld_val = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_op(input logic we, input logic [1:0] sz, input logic [7:0] addr,
                        input logic [31:0] wd, output logic [31:0] rd);
    rd = 32'hDEAD_BEEF;
    @(negedge clk);
    for (int k = 0; k < 50 && !req_ready; k++) @(negedge clk);
    req_valid = 1'b1; req_write = we; req_size = sz; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    for (int k = 0; k < 20; k++) begin
      if (rsp_valid) begin rd = rsp_rdata; break; end
      @(negedge clk);
    end
  endtask

  typedef struct packed {
    logic        we;
    logic [1:0]  sz;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [31:0] init;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b0, 2'd0, 8'h11, 32'h0,        32'hAABBCCDD, 32'h000000CC, 4'd1 },  // R1 byte lane 1
    '{1'b0, 2'd1, 8'h12, 32'h0,        32'hAABBCCDD, 32'h0000AABB, 4'd1 },  // R1 upper half
    '{1'b0, 2'd2, 8'h10, 32'h0,        32'hAABBCCDD, 32'hAABBCCDD, 4'd1 },  // R1 word
    '{1'b0, 2'd0, 8'h13, 32'h0,        32'hAABBCCDD, 32'h000000AA, 4'd1 },  // R1 byte lane 3
    '{1'b1, 2'd0, 8'h13, 32'h5A,       32'h11223344, 32'h5A223344, 4'd2 },  // R2 byte lane 3
    '{1'b1, 2'd1, 8'h16, 32'hBEEF,     32'h11223344, 32'hBEEF3344, 4'd2 },  // R2 upper half
    '{1'b1, 2'd0, 8'h10, 32'h77,       32'h11223344, 32'h11223377, 4'd2 },  // R2 byte lane 0
    '{1'b0, 2'd2, 8'h24, 32'h0,        32'h0F800ABC, 32'h01F00ABC, 4'd5 },  // R5 both moves
    '{1'b0, 2'd2, 8'h24, 32'h0,        32'h0A000000, 32'h00A00000, 4'd5 },  // R5 data only
    '{1'b0, 2'd0, 8'h28, 32'h0,        32'h000003E7, 32'h000000FF, 4'd6 },  // R6 dma field down
    '{1'b1, 2'd0, 8'h28, 32'h12,       32'h00000119, 32'h0000021A, 4'd7 },  // R7 dma field up
    '{1'b1, 2'd0, 8'h28, 32'h07,       32'h00000000, 32'h00000003, 4'd7 },  // R7 reserved cleared
    '{1'b1, 2'd0, 8'h29, 32'hFF,       32'h12345678, 32'h12345678, 4'd8 },  // R8 dropped
    '{1'b1, 2'd2, 8'h34, 32'h0,        32'h0,        32'h00000004, 4'd9 },  // R9 forced
    '{1'b1, 2'd2, 8'h34, 32'hFFFF0000, 32'h0,        32'hFFFF0004, 4'd9 },  // R9 forced
    '{1'b1, 2'd1, 8'h04, 32'hFFFF,     32'hAAAA0000, 32'hAAAA8FFF, 4'd10},  // R10 boundary cleared
    '{1'b0, 2'd2, 8'h40, 32'h0,        32'h00100000, 32'h00180000, 4'd11},  // R11 flag added
    '{1'b0, 2'd2, 8'h40, 32'h0,        32'h00000000, 32'h00000000, 4'd11},  // R11 no flag
    '{1'b0, 2'd1, 8'hFE, 32'h0,        32'h12345678, 32'h00005678, 4'd12}   // R12 low half
  };

  initial begin
    logic [31:0] rd;
    int rc0, wc0;
    checks = 0; errors = 0; done = 0;
    rd_cnt = 0; wr_cnt = 0;
    ld_en = 0; ld_idx = 0; ld_val = 0;
    rst_n = 1'b0; cfg_big_endian = 1'b0; cfg_vendor_ver = 8'h13;
    req_valid = 0; req_write = 0; req_size = 0; req_addr = 0; req_wdata = 0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state (R1)
    chk("R1 reset ready", {31'd0, req_ready}, 32'd1);
    chk("R1 reset idle strobes", {29'd0, rsp_valid, bk_rd, bk_wr}, 32'd0);

    // R13: shadow starts at zero
    preload(8'h0C, 32'h55555555);
    run_op(1'b1, 2'd1, 8'h0E, 32'h1234, rd);
    chk("R13 shadow reset zero", mem[3], 32'h12340000);

    // R3: transfer-mode write is held back
    preload(8'h0C, 32'h55555555);
    rc0 = rd_cnt; wc0 = wr_cnt;
    run_op(1'b1, 2'd1, 8'h0C, 32'hABCD, rd);
    @(negedge clk);
    chk("R3 word untouched", mem[3], 32'h55555555);
    chk("R3 no backing access", rd_cnt - rc0 + wr_cnt - wc0, 32'd0);

    // R4: command write merges shadow, no read
    rc0 = rd_cnt;
    run_op(1'b1, 2'd1, 8'h0E, 32'h0042, rd);
    @(negedge clk);
    chk("R4 merged word", mem[3], 32'h0042ABCD);
    chk("R4 no backing read", rd_cnt - rc0, 32'd0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      preload(VEC[v].addr, VEC[v].init);
      run_op(VEC[v].we, VEC[v].sz, VEC[v].addr, VEC[v].wd, rd);
      @(negedge clk);
      checks++;
      if (VEC[v].we ? (mem[VEC[v].addr[7:2]] !== VEC[v].exp) : (rd !== VEC[v].exp)) begin
        errors++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[v].req, v,
                 VEC[v].we ? mem[VEC[v].addr[7:2]] : rd, VEC[v].exp);
      end
    end

    // R8: dropped write makes no backing access
    rc0 = rd_cnt; wc0 = wr_cnt;
    run_op(1'b1, 2'd0, 8'h29, 32'h0F, rd);
    @(negedge clk);
    chk("R8 no backing access", rd_cnt - rc0 + wr_cnt - wc0, 32'd0);

    // R11: older vendor code gets no extra flag
    cfg_vendor_ver = 8'h12;
    preload(8'h40, 32'h00100000);
    run_op(1'b0, 2'd2, 8'h40, 32'h0, rd);
    chk("R11 vendor 0x12", rd, 32'h00100000);
    cfg_vendor_ver = 8'h13;

    // R13: byte-reversed backing bus
    cfg_big_endian = 1'b1;
    preload(8'h10, 32'h11223344);
    run_op(1'b0, 2'd2, 8'h10, 32'h0, rd);
    chk("R13 big-endian word read", rd, 32'h44332211);
    preload(8'h28, rev(32'h000003E7));
    run_op(1'b0, 2'd0, 8'h28, 32'h0, rd);
    chk("R13 big-endian hctl read", rd, 32'h000000FF);
    preload(8'h28, rev(32'h00000119));
    run_op(1'b1, 2'd0, 8'h28, 32'h12, rd);
    @(negedge clk);
    chk("R13 big-endian hctl write", mem[10], rev(32'h0000021A));
    preload(8'h10, rev(32'h11223344));
    run_op(1'b1, 2'd1, 8'h12, 32'hCAFE, rd);
    @(negedge clk);
    chk("R13 big-endian half write", mem[4], rev(32'hCAFE3344));
    run_op(1'b1, 2'd2, 8'h34, 32'h0, rd);
    @(negedge clk);
    chk("R9 big-endian forced bit", mem[13], rev(32'h00000004));
    cfg_big_endian = 1'b0;

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule